// File: doc/BRIEF.md
# Gatable Astable / Monostable Pulse Timer

This block is a synchronous timer that works in one of two ways. As a gated oscillator it produces a free-running square wave on `q` and its inverse on `q_n` for as long as either astable enable is asserted. As a one-shot it produces a single fixed-width pulse when it sees a qualifying trigger edge. A retrigger input can stretch that pulse, and a count mode makes the pulse several oscillator periods long. Every duration is a whole number of clock cycles set by the parameter `HALF_CNT`, which is the number of clock cycles in one half-period of the oscillator tap `osc_out`.

One oscillator core serves both modes. In astable mode it runs freely. In monostable mode it runs only while a pulse is active, and the pulse ends on an oscillator period boundary. All control inputs are asynchronous. Each one passes through a two-flop synchronizer, so any input change takes effect at the third rising clock edge after it. `rst_n` is asynchronous active-low, and its release is expected to be synchronous to `clk`.

Top module: `pulse_timer`

## Requirements
- R1: While `rst_n` is low, and afterwards until a trigger or an astable enable arrives, `q`=0, `q_n`=1 and `osc_out`=0.
- R2: Astable mode is active when `astable_hi`=1, when `astable_lo_n`=0, or both. When neither enable is active and no one-shot pulse is running, `q` and `osc_out` are held at 0.
- R3: Astable mode starts from `q`=0 and `osc_out`=0 at the edge where the enable takes effect. `q` then toggles every 2*HALF_CNT cycles, so its period is 4*HALF_CNT cycles with a 50% duty cycle.
- R4: In astable mode `osc_out` toggles every HALF_CNT cycles, so its period is half the period of `q`.
- R5: In monostable mode a one-shot starts on either of two edges: a rising edge of `trig_pos` while `trig_neg`=0, or a falling edge of `trig_neg` while `trig_pos`=1. `q` then stays high for exactly 2*HALF_CNT cycles, whatever the length of the trigger. A trigger edge that arrives while a pulse is running is ignored.
- R6: A rising edge of `trig_pos` while `trig_neg`=1 starts no pulse.
- R7: A rising edge of `retrig` starts or restarts a pulse. While `retrig` stays high the pulse keeps restarting, so `q` falls 2*HALF_CNT*k cycles after the last cycle in which `retrig` was seen high. Here k=1, or k=CNT_N in count mode.
- R8: While `ext_clear`=1, `q` and `osc_out` are driven to 0, and any running pulse or oscillation ends. A trigger or retrigger edge seen in the same cycle as `ext_clear` is discarded.
- R9: With `count_mode`=1 a one-shot lasts CNT_N oscillator periods, which is CNT_N*2*HALF_CNT cycles.
- R10: `q_n` is the inverse of `q` in every cycle. Both outputs come from registers.
- R11: During a one-shot, `osc_out` starts low at the trigger and toggles every HALF_CNT cycles until the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pos | input | 1 | Positive-edge one-shot trigger |
| trig_neg | input | 1 | Negative-edge one-shot trigger |
| astable_hi | input | 1 | Astable enable, active high |
| astable_lo_n | input | 1 | Astable enable, active low |
| retrig | input | 1 | Retrigger, level-held extension |
| ext_clear | input | 1 | Forces the outputs low and ends any activity |
| count_mode | input | 1 | Selects a one-shot width of CNT_N oscillator periods |
| q | output | 1 | Main output |
| q_n | output | 1 | Complement of q |
| osc_out | output | 1 | Oscillator tap at twice the q frequency |

## Verification
The bench builds the block with HALF_CNT=3 and CNT_N=3. A plain one-shot is then 6 cycles, a count-mode one-shot is 18 cycles and an astable `q` period is 12 cycles. These short values let a single run cover several full astable periods through each enable, retrigger holds that span multiple base widths, and a clear that lands in the middle of a pulse. A clock-by-clock reference model that includes the synchronizer delay compares all three outputs on every cycle, and it is backed by directed pulse-width measurements.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  localparam int NUM_IN  = 7;
  localparam int IX_TPOS = 0;
  localparam int IX_TNEG = 1;
  localparam int IX_AHI  = 2;
  localparam int IX_ALON = 3;
  localparam int IX_RTRG = 4;
  localparam int IX_CLR  = 5;
  localparam int IX_CMOD = 6;
  // synchronizer reset levels: the active-low enable idles high
  localparam logic [NUM_IN-1:0] SYNC_RST = 7'b000_1000;
endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= RST_VAL[i];
        stage2[i] <= RST_VAL[i];
      end else begin
        stage1[i] <= async_in[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign sync_out = stage2;
endmodule

// File: rtl/pt_edge.sv
module pt_edge #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] last_q;
  logic [WIDTH-1:0] last_d;

  always_comb begin
    last_d = level;
    rise   = level & ~last_q;
    fall   = ~level & last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_VAL;
    else        last_q <= last_d;
  end
endmodule

// File: rtl/pt_timebase.sv
module pt_timebase #(
  parameter int HALF_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick,
  output logic period_done,
  output logic osc
);
  localparam int TBW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
  localparam logic [TBW-1:0] LAST = TBW'(HALF_CNT - 1);

  logic [TBW-1:0] cnt_q, cnt_d;
  logic           osc_q, osc_d;
  logic           cnt_en;

  always_comb begin
    cnt_en      = run & ~clr;
    tick        = cnt_en & (cnt_q == LAST);
    period_done = tick & osc_q;
    cnt_d       = cnt_q;
    osc_d       = osc_q;
    if (clr) begin
      cnt_d = '0;
      osc_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
      osc_d = tick ? ~osc_q : osc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      osc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      osc_q <= osc_d;
    end
  end

  assign osc = osc_q;

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r4_osc_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (osc != $past(osc)));
  a_r8_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!osc && cnt_q == '0));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int HALF_CNT = 3,
  parameter int CNT_N    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pos,
  input  logic trig_neg,
  input  logic astable_hi,
  input  logic astable_lo_n,
  input  logic retrig,
  input  logic ext_clear,
  input  logic count_mode,
  output logic q,
  output logic q_n,
  output logic osc_out
);
  localparam int PW = $clog2(CNT_N + 1);
  localparam logic [PW-1:0] LAST_N = PW'(CNT_N - 1);

  logic [NUM_IN-1:0] raw_in, lvl, rise, fall;

  assign raw_in = {count_mode, ext_clear, retrig, astable_lo_n,
                   astable_hi, trig_neg, trig_pos};

  pt_sync #(.WIDTH(NUM_IN), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(lvl));

  pt_edge #(.WIDTH(NUM_IN), .RST_VAL(SYNC_RST)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(lvl), .rise(rise), .fall(fall));

  // control state
  logic          q_q, q_d, qn_q, qn_d;
  logic          pulse_q, pulse_d;
  logic          ast_q, ast_d;
  logic [PW-1:0] per_q, per_d;

  // decoded conditions
  logic ast_en, ast_entry, clr_s, trig_hit, retrig_hit, fire;
  logic pulse_end, per_last;
  logic tb_clr, tb_run, tb_tick, tb_pdone, tb_osc;

  always_comb begin
    clr_s      = lvl[IX_CLR];
    ast_en     = lvl[IX_AHI] | ~lvl[IX_ALON];
    ast_entry  = ast_en & ~ast_q;
    trig_hit   = (rise[IX_TPOS] & ~lvl[IX_TNEG]) |
                 (fall[IX_TNEG] & lvl[IX_TPOS]);
    retrig_hit = rise[IX_RTRG] | (pulse_q & lvl[IX_RTRG]);
    fire       = ~clr_s & ~ast_en & ((trig_hit & ~pulse_q) | retrig_hit);
    per_last   = lvl[IX_CMOD] ? (per_q == LAST_N) : (per_q == '0);
    pulse_end  = pulse_q & tb_pdone & per_last;
    tb_clr     = clr_s | ast_entry | fire | (~ast_en & ~pulse_q);
    tb_run     = ast_en | pulse_q;
  end

  pt_timebase #(.HALF_CNT(HALF_CNT)) u_tb (
    .clk(clk), .rst_n(rst_n), .clr(tb_clr), .run(tb_run),
    .tick(tb_tick), .period_done(tb_pdone), .osc(tb_osc));

  // next-state
  always_comb begin
    q_d     = q_q;
    pulse_d = pulse_q;
    per_d   = per_q;
    ast_d   = ast_en & ~clr_s;
    if (clr_s) begin
      q_d     = 1'b0;
      pulse_d = 1'b0;
      per_d   = '0;
    end else if (ast_en) begin
      pulse_d = 1'b0;
      per_d   = '0;
      if (ast_entry)     q_d = 1'b0;
      else if (tb_pdone) q_d = ~q_q;
    end else if (fire) begin
      q_d     = 1'b1;
      pulse_d = 1'b1;
      per_d   = '0;
    end else if (pulse_q) begin
      if (pulse_end) begin
        q_d     = 1'b0;
        pulse_d = 1'b0;
        per_d   = '0;
      end else if (tb_pdone) begin
        per_d = per_q + 1'b1;
      end
    end else begin
      q_d = 1'b0;
    end
    qn_d = ~q_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q     <= 1'b0;
      qn_q    <= 1'b1;
      pulse_q <= 1'b0;
      ast_q   <= 1'b0;
      per_q   <= '0;
    end else begin
      q_q     <= q_d;
      qn_q    <= qn_d;
      pulse_q <= pulse_d;
      ast_q   <= ast_d;
      per_q   <= per_d;
    end
  end

  assign q       = q_q;
  assign q_n     = qn_q;
  assign osc_out = tb_osc;

  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    q_n == ~q);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (!q && !pulse_q));
  a_r5_fire_raises: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (q && pulse_q && !osc_out));
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ast_en && !pulse_q && !fire) |=> !q);
  a_r9_per_bound: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= LAST_N);
  a_r3_astable_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_en && !clr_s) |=> !pulse_q);
endmodule

// File: tb/sim_pulse_timer.sv
module sim_pulse_timer;
  localparam int H = 3;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_pos, trig_neg, astable_hi, astable_lo_n, retrig, ext_clear, count_mode;
  logic q, q_n, osc_out;

  always #10 clk = ~clk;

  pulse_timer #(.HALF_CNT(H), .CNT_N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_pos(trig_pos), .trig_neg(trig_neg),
    .astable_hi(astable_hi), .astable_lo_n(astable_lo_n), .retrig(retrig),
    .ext_clear(ext_clear), .count_mode(count_mode),
    .q(q), .q_n(q_n), .osc_out(osc_out));

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    cyc      = 0;

  // behavioural reference model
  logic [6:0] d1, d2, d3, s, sp;
  bit  mq, mosc, mp, mastq;
  int  me, ma, tgt;
  bit  aen, fire;
  localparam logic [6:0] IDLE_IN = 7'b000_1000;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1 = IDLE_IN; d2 = IDLE_IN; d3 = IDLE_IN;
      mq = 0; mosc = 0; mp = 0; mastq = 0; me = 0; ma = 0;
    end else begin
      s = d2; sp = d3;
      aen = s[2] || !s[3];
      if (s[5]) begin
        mp = 0; mastq = 0; mq = 0; mosc = 0;
      end else if (aen) begin
        if (!mastq) begin ma = 0; mastq = 1; end
        else ma = ma + 1;
        mp = 0;
        mq   = ((ma / (2*H)) % 2) == 1;
        mosc = ((ma / H) % 2) == 1;
      end else begin
        mastq = 0;
        tgt = s[6] ? N : 1;
        fire = (!mp && ((s[0] && !sp[0] && !s[1]) || (!s[1] && sp[1] && s[0])))
               || (s[4] && !sp[4]) || (mp && s[4]);
        if (fire) begin mp = 1; me = 0; end
        else if (mp) begin
          me = me + 1;
          if (me == 2*H*tgt) mp = 0;
        end
        mq   = mp;
        mosc = mp && ((me / H) % 2 == 1);
      end
      d3 = d2; d2 = d1;
      d1 = {count_mode, ext_clear, retrig, astable_lo_n, astable_hi, trig_neg, trig_pos};
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (q !== mq || osc_out !== mosc) begin
        n_fail++;
        $display("FAIL %s cycle %0d: q=%b osc=%b expected q=%b osc=%b",
                 cur_req, cyc, q, osc_out, mq, mosc);
      end
      n_checks++;
      if (q_n !== ~q) begin
        n_fail++;
        $display("FAIL R10 cycle %0d: q_n=%b expected %b", cyc, q_n, ~q);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: cycle %0d expected completion before 20000", cyc);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // measures the next high interval of q (0 if none starts within 12 cycles)
  task automatic high_width(output int w);
    int waited = 0;
    w = 0;
    while (!q && waited < 12) begin @(negedge clk); waited++; end
    while (q && w < 200) begin @(negedge clk); w++; end
  endtask

  int w;

  initial begin
    rst_n = 0; trig_pos = 0; trig_neg = 0; astable_hi = 0; astable_lo_n = 1;
    retrig = 0; ext_clear = 0; count_mode = 0;
    wait_cyc(5);
    check("R1 reset q", q, 0);
    check("R1 reset q_n", q_n, 1);
    check("R1 reset osc", osc_out, 0);
    rst_n = 1;
    wait_cyc(10);
    check("R1 idle q after release", q, 0);

    // R5 / R11: short and long positive triggers
    cur_req = "R5";
    trig_pos = 1; @(negedge clk); trig_pos = 0;
    high_width(w); check("R5 short trigger width", w, 2*H);
    wait_cyc(4);
    cur_req = "R11";
    trig_pos = 1;
    high_width(w); check("R5 long trigger width", w, 2*H);
    wait_cyc(10); trig_pos = 0; wait_cyc(4);

    // R6: positive edge blocked while trig_neg high, then R5 falling trig_neg
    cur_req = "R6";
    trig_neg = 1; wait_cyc(4);
    trig_pos = 1; wait_cyc(10);
    check("R6 no pulse while trig_neg high", q, 0);
    cur_req = "R5";
    trig_neg = 0;
    high_width(w); check("R5 falling trig_neg width", w, 2*H);
    trig_pos = 0; wait_cyc(4);

    // R5: second trigger inside a pulse is ignored
    trig_pos = 1; @(negedge clk); trig_pos = 0; wait_cyc(2);
    trig_pos = 1; @(negedge clk); trig_pos = 0;
    wait_cyc(12);
    check("R5 retrigger by trig_pos ignored", q, 0);

    // R7: retrigger pulse and held retrigger
    cur_req = "R7";
    retrig = 1; @(negedge clk); retrig = 0;
    high_width(w); check("R7 single retrig width", w, 2*H);
    wait_cyc(4);
    retrig = 1; wait_cyc(15); retrig = 0;
    wait_cyc(30);
    retrig = 1; @(negedge clk); retrig = 0;
    wait_cyc(2);
    retrig = 1; @(negedge clk); retrig = 0;
    wait_cyc(20);

    // R8: clear mid-pulse and clear with simultaneous trigger
    cur_req = "R8";
    trig_pos = 1; @(negedge clk); trig_pos = 0; wait_cyc(4);
    ext_clear = 1; wait_cyc(3);
    check("R8 clear ends pulse", q, 0);
    ext_clear = 0; wait_cyc(4);
    ext_clear = 1; trig_pos = 1; wait_cyc(4);
    ext_clear = 0; wait_cyc(10);
    check("R8 trigger with clear discarded", q, 0);
    trig_pos = 0; wait_cyc(4);

    // R9: count mode
    cur_req = "R9";
    count_mode = 1; wait_cyc(4);
    trig_pos = 1; @(negedge clk); trig_pos = 0;
    high_width(w); check("R9 count mode width", w, 2*H*N);
    retrig = 1; wait_cyc(5); retrig = 0;
    wait_cyc(30);
    count_mode = 0; wait_cyc(4);

    // R3 / R4: astable through each enable
    cur_req = "R3";
    astable_hi = 1;
    high_width(w); check("R3 astable high half", w, 2*H);
    wait_cyc(40);
    cur_req = "R2";
    astable_hi = 0; wait_cyc(5);
    check("R2 gated off q", q, 0);
    check("R2 gated off osc", osc_out, 0);
    cur_req = "R4";
    astable_lo_n = 0; wait_cyc(50);
    ext_clear = 1; wait_cyc(3);
    check("R8 clear stops astable", q, 0);
    ext_clear = 0; wait_cyc(20);
    astable_hi = 1; wait_cyc(10); astable_lo_n = 1; wait_cyc(30);
    astable_hi = 0; wait_cyc(3);
    trig_pos = 1; @(negedge clk); trig_pos = 0;
    wait_cyc(20);
    check("R2 idle after gating", q, 0);
    finish_run();
  end
endmodule